// File: doc/BRIEF.md
# Frame-Sync Supervisor with Rate Detection and Powerdown

This block runs on the PCM bit clock and watches the single frame-sync input of a two-channel codec. Frames arrive once every 125 µs, so the number of bit-clock cycles between two frame-sync rising edges shows which of the two allowed bit-clock rates is present. A period of 256 cycles means 2.048 MHz and a period of 512 cycles means 4.096 MHz. The block reports the rate only after two consecutive periods give the same answer. It then holds that rate until the next powerdown.

Once a rate is known, the block times how long frame sync stays absent. The limit is a fixed 500 µs, which is 1024 cycles at the slow rate and 2048 cycles at the fast rate. When the limit is reached, one powerdown flag covering both channels is raised and the rate is declared unknown. The next frame-sync rising edge clears powerdown one clock later and starts a fresh rate measurement. Frame sync is synchronous to the bit clock and acts only on its rising edge, whatever the width of the pulse.

Top module: `fsync_pwr_supervisor`

## Requirements
- R1: After asynchronous reset, `pwrdn` is 1, `rate_valid` is 0 and `rate_fast` is 0. `pwrdn` stays 1 until the first time `rate_valid` is raised.
- R2: The period is the number of bit-clock cycles from one frame-sync rising edge to the next. When two consecutive periods are both 256, `rate_valid` becomes 1 with `rate_fast` = 0, on the clock edge that samples the rising edge ending the second period. On that first lock `pwrdn` falls on the same edge.
- R3: When two consecutive periods are both 512, `rate_valid` becomes 1 with `rate_fast` = 1, with the same timing as R2.
- R4: A period other than 256 or 512 restarts the measurement. Two consecutive periods that are valid but differ from each other (256 then 512) do not set `rate_valid`. The first rising edge after reset or after powerdown only starts the measurement.
- R5: While `rate_valid` is 1, periods of any length leave `rate_valid` and `rate_fast` unchanged.
- R6: While `pwrdn` is 0, suppose the last frame-sync rising edge was sampled at clock edge E and no further rising edge arrives. Then `pwrdn` becomes 1 at edge E+1024 when `rate_fast` = 0, and at edge E+2048 when `rate_fast` = 1. It is still 0 at the edge just before.
- R7: A frame-sync pulse of any width from 1 cycle upward counts as a single rising edge. A long pulse does not retrigger the measurement.
- R8: When `pwrdn` is 1 after a rate has been locked at least once, a frame-sync rising edge clears `pwrdn` on the clock edge that samples it. `rate_valid` then stays 0 until two new matching periods are measured, and the newly measured rate replaces the old one.
- R9: On the edge where `pwrdn` rises because of the timeout, `rate_valid` falls to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCM bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | Frame sync, synchronous to clk |
| rate_fast | output | 1 | 1 = 4.096 MHz detected, 0 = 2.048 MHz |
| rate_valid | output | 1 | Detected rate is locked |
| pwrdn | output | 1 | Powerdown for both channels |

## Verification
The bench sweeps the frame period across both sides of each legal value (254 to 258, 510 to 514) and two unrelated lengths. A counter that is off by one at the compare would lock on a neighbouring period or miss the exact one. It places the idle timeout to the exact edge at both rates: a design whose threshold ignored the detected rate, or was off by one, would power down one edge early or late. It feeds alternating valid periods and long pulses, which catch a design that locks on any two valid periods or retriggers on a held-high level. It also checks wake-up from powerdown, where a design that kept the stale rate valid, or cleared powerdown late, shows the wrong flags one cycle after the edge.

// File: rtl/fsync_pwr_supervisor.sv
module fsync_pwr_supervisor #(
  parameter int SLOW_FRAME = 256,
  parameter int FAST_FRAME = 512,
  parameter int SLOW_IDLE  = 1024,
  parameter int FAST_IDLE  = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync,
  output logic rate_fast,
  output logic rate_valid,
  output logic pwrdn
);
  localparam int CW = $clog2(FAST_IDLE) + 1;
  localparam logic [CW-1:0] SF  = CW'(SLOW_FRAME);
  localparam logic [CW-1:0] FF  = CW'(FAST_FRAME);
  localparam logic [CW-1:0] SI1 = CW'(SLOW_IDLE - 1);
  localparam logic [CW-1:0] FI1 = CW'(FAST_IDLE - 1);

  logic          fs_q, seen, hits, cand, locked_once;
  logic [CW-1:0] per_cnt;

  wire          edge_in  = fsync & ~fs_q;
  wire [CW-1:0] span     = per_cnt + 1'b1;
  wire [CW-1:0] idle_lim = rate_fast ? FI1 : SI1;
  wire          timeout  = !pwrdn && !edge_in && (per_cnt == idle_lim);
  wire          hit_slow = (span == SF);
  wire          hit_fast = (span == FF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q        <= 1'b0;
      per_cnt     <= '0;
      seen        <= 1'b0;
      hits        <= 1'b0;
      cand        <= 1'b0;
      locked_once <= 1'b0;
      rate_fast   <= 1'b0;
      rate_valid  <= 1'b0;
      pwrdn       <= 1'b1;
    end else begin
      fs_q <= fsync;
      if (edge_in)        per_cnt <= '0;
      else if (~&per_cnt) per_cnt <= per_cnt + 1'b1;

      if (timeout) begin
        pwrdn      <= 1'b1;
        rate_valid <= 1'b0;
        seen       <= 1'b0;
        hits       <= 1'b0;
      end else if (edge_in) begin
        if (pwrdn && locked_once) pwrdn <= 1'b0;
        if (!rate_valid) begin
          if (!seen) begin
            seen <= 1'b1;
            hits <= 1'b0;
          end else if (hit_slow || hit_fast) begin
            if (hits && (cand == hit_fast)) begin
              rate_valid  <= 1'b1;
              rate_fast   <= hit_fast;
              locked_once <= 1'b1;
              pwrdn       <= 1'b0;
            end else begin
              hits <= 1'b1;
              cand <= hit_fast;
            end
          end else begin
            hits <= 1'b0;
          end
        end
      end
    end
  end

  // R1
  no_early_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_once |-> pwrdn);

  // R2
  lock_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rate_valid) |-> $past(fsync && !fs_q));

  // R5
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_valid && $past(rate_valid)) |-> $stable(rate_fast));

  // R8
  wake_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwrdn) |-> $past(fsync && !fs_q));

  // R9
  pd_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwrdn) |-> !rate_valid);
endmodule

// File: tb/test_fsync_pwr_supervisor.sv
module test_fsync_pwr_supervisor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 1'b0;
  logic rate_fast, rate_valid, pwrdn;
  int   n_chk = 0;
  int   n_fail = 0;
  int   cyc = 0;

  fsync_pwr_supervisor i_fsync_pwr_supervisor (
    .clk(clk), .rst_n(rst_n), .fsync(fsync),
    .rate_fast(rate_fast), .rate_valid(rate_valid), .pwrdn(pwrdn)
  );

  always #10 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fsync = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic frame(input int per, input int w);
    @(negedge clk);
    fsync = 1'b1;
    repeat (w) @(negedge clk);
    fsync = 1'b0;
    repeat (per - w - 1) @(negedge clk);
  endtask

  task automatic idle_check(input int lim, input string tag);
    @(negedge clk);
    fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0;
    repeat (lim - 1) @(negedge clk);
    chk({tag, " pwrdn before limit"}, pwrdn, 1'b0);
    @(negedge clk);
    chk({tag, " pwrdn at limit"}, pwrdn, 1'b1);
    chk("R9 valid dropped", rate_valid, 1'b0);
  endtask

  initial begin
    int plist [12] = '{254, 255, 256, 257, 258, 510, 511, 512, 513, 514, 300, 384};
    do_reset();
    @(negedge clk);
    chk("R1 pwrdn", pwrdn, 1'b1);
    chk("R1 valid", rate_valid, 1'b0);
    chk("R1 fast", rate_fast, 1'b0);

    foreach (plist[i]) begin
      int p = plist[i];
      logic ev = (p == 256) || (p == 512);
      do_reset();
      repeat (3) frame(p, 1);
      chk($sformatf("R2 R3 R4 valid p=%0d", p), rate_valid, ev);
      chk($sformatf("R1 R2 pwrdn p=%0d", p), pwrdn, !ev);
      if (ev) chk($sformatf("R3 fast p=%0d", p), rate_fast, p == 512);
    end

    do_reset();
    frame(256, 1); frame(512, 1); frame(256, 1); frame(256, 1);
    chk("R4 alternating no lock", rate_valid, 1'b0);
    frame(256, 1);
    chk("R4 lock after match", rate_valid, 1'b1);
    chk("R4 slow", rate_fast, 1'b0);

    do_reset();
    frame(256, 1); frame(300, 1); frame(256, 1);
    chk("R4 bad period restarts", rate_valid, 1'b0);

    for (int w = 1; w <= 4; w++) begin
      do_reset();
      repeat (3) frame(256, w);
      chk($sformatf("R7 width %0d lock", w), rate_valid, 1'b1);
    end
    do_reset();
    repeat (3) frame(256, 200);
    chk("R7 long pulse lock", rate_valid, 1'b1);
    chk("R7 long pulse slow", rate_fast, 1'b0);

    repeat (3) frame(512, 1);
    chk("R5 stays valid", rate_valid, 1'b1);
    chk("R5 rate held", rate_fast, 1'b0);
    chk("R5 no pwrdn", pwrdn, 1'b0);

    idle_check(1024, "R6 slow");

    do_reset();
    repeat (3) frame(512, 1);
    chk("R3 fast lock", rate_fast, 1'b1);
    idle_check(2048, "R6 fast");

    @(negedge clk);
    fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0;
    chk("R8 wake clears pwrdn", pwrdn, 1'b0);
    chk("R8 not valid on wake", rate_valid, 1'b0);
    repeat (254) @(negedge clk);
    frame(256, 1);
    chk("R8 one period not enough", rate_valid, 1'b0);
    frame(256, 1);
    chk("R8 relock", rate_valid, 1'b1);
    chk("R8 new rate slow", rate_fast, 1'b0);
    chk("R8 pwrdn low", pwrdn, 1'b0);

    summary();
  end
endmodule